// File: doc/BRIEF.md
# Paged Serial Register Bank

This block is a configuration register file reached over a serial peripheral interface. Each page holds thirty-two byte-wide locations; a pointer register selects which page the host addresses. A host uses it to set configuration bytes such as a 32-bit oscillator frequency word (four bytes, page 0, offsets 03h for the low byte up to 06h for the high byte) and a 16-bit phase word (page 0, offsets 07h low byte and 08h high byte), gains and lane controls. The stored contents appear on a flattened output bus for the logic they steer. One page reflects a read-only status input instead of storage.

The serial pins are sampled in the system clock domain. While chip select is low, the host first sends an 8-bit header, most significant bit first. Its first bit is the direction (1 = read, 0 = write). Two count bits follow, where a value n means n+1 data bytes. The last five bits are the start offset. Data bytes follow most significant bit first, and the offset advances by one after every byte. Offset 1Fh is the page pointer in every page. On page 0, offset 00h carries a shared-pin mode bit and a self-clearing soft reset bit.

Top module: `spiPagedRegs`

## Requirements
- R1: After reset every byte of `regOut` is zero, and `sdoOut` and `sdioOe` are low.
- R2: A write frame consists of a header bit 0, two count bits, a 5-bit offset (all MSB first) and then data MSB first. It stores the byte at that offset of the selected page, visible on `regOut` at bit position (page*32+offset)*8.
- R3: In a frame of n+1 bytes the offset increments by one after each byte, for both writes and reads.
- R4: A read frame (header bit 1) returns the addressed byte MSB first. Each bit is driven after an SCLK falling edge and is valid at the next rising edge, the first bit after the falling edge that ends the header.
- R5: Offset 1Fh is the page pointer on every page. Its low three bits select the page, its upper five bits read as 0, and `regOut` shows the pointer at offset 1Fh of every stored page.
- R6: Writes and reads reach only the selected page; other pages keep their contents.
- R7: With page 4 selected, reads return `statusIn[offset*8 +: 8]` and writes have no effect.
- R8: Pages 5 to 7 have no storage: reads return 00h and writes have no effect.
- R9: When bit 7 of page 0 offset 00h is 1, read data leaves on `sdioOut` with `sdioOe` high during the data phase and `sdoOut` stays low. When that bit is 0, read data leaves on `sdoOut` and `sdioOe` stays low.
- R10: Writing a byte with bit 6 set to page 0 offset 00h clears every register, including the page pointer and the mode bit, and bit 6 reads back 0.
- R11: Raising `csN` ends a frame. An incomplete byte is discarded, and the next frame starts with a new header.
- R12: Data bytes beyond the count given in the header are ignored.
- R13: Driving `rstN` low at any time returns all registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdioIn | input | 1 | Host data in (shared data pin in 3-wire mode) |
| sdioOut | output | 1 | Read data on the shared pin in 3-wire mode |
| sdioOe | output | 1 | Output enable for the shared pin |
| sdoOut | output | 1 | Read data pin in 4-wire mode |
| statusIn | input | 256 | Status bytes returned by page 4, byte k at bits k*8+7:k*8 |
| regOut | output | 1024 | Stored bytes of pages 0 to 3, byte (page*32+offset) |

## Verification
The properties assume that the host holds `csN` high whenever it is not transferring and that `csN` rises only after the last SCLK falling edge has been seen, so no register may change once chip select has been high for a few clocks. The stimulus keeps every SCLK phase eight system clocks long, well above the synchronizer latency. It raises `csN` only with SCLK low and several clocks after the final edge, except in the deliberate mid-byte abort. Reset is released with `csN` high. This ensures the idle-pin properties start from a quiet bus.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  localparam int ADDR_W     = 5;
  localparam int PAGE_W     = 3;
  localparam int BYTE_W     = 8;
  localparam int CNT_W      = 2;
  localparam int PAGE_DEPTH = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] PAGE_PTR_ADDR = '1;
  localparam logic [ADDR_W-1:0] MODE_ADDR     = '0;
  localparam int WIRE3_BIT   = 7;
  localparam int SOFTRST_BIT = 6;

  typedef enum logic [1:0] {PH_HDR, PH_DATA, PH_DONE} phase_t;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] wrData;
  } regStrobe_t;
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              sdi,
  input  logic [BYTE_W-1:0] rdData,
  input  logic              threeWire,
  output regStrobe_t        strb,
  output logic              sdoOut,
  output logic              sdioOut,
  output logic              sdioOe
);
  localparam logic [2:0] SYNC_RST = 3'b010;
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  // pin synchronizer chain: {sclk, csN, sdi}
  logic [2:0] syncQ [SYNC_STAGES];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= SYNC_RST;
    end else begin
      syncQ[0] <= {sclk, csN, sdi};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  logic sclkS, csS, sdiS, sclkD;
  assign sclkS = syncQ[SYNC_STAGES-1][2];
  assign csS   = syncQ[SYNC_STAGES-1][1];
  assign sdiS  = syncQ[SYNC_STAGES-1][0];

  logic rise, fall;
  assign rise = sclkS && !sclkD && !csS;
  assign fall = !sclkS && sclkD && !csS;

  phase_t            phase;
  logic [BIT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shIn, shOut, nextSh;
  logic              isRead;
  logic [CNT_W-1:0]  bytesLeft;
  logic [ADDR_W-1:0] addr;
  logic              outBit, outEn;
  logic              byteEnd;

  always_comb begin
    nextSh      = {shIn[BYTE_W-2:0], sdiS};
    byteEnd     = rise && (bitCnt == LAST_BIT);
    strb.wrEn   = byteEnd && (phase == PH_DATA) && !isRead;
    strb.addr   = addr;
    strb.wrData = nextSh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD     <= 1'b0;
      phase     <= PH_HDR;
      bitCnt    <= '0;
      shIn      <= '0;
      shOut     <= '0;
      isRead    <= 1'b0;
      bytesLeft <= '0;
      addr      <= '0;
      outBit    <= 1'b0;
      outEn     <= 1'b0;
    end else begin
      sclkD <= sclkS;
      if (csS) begin
        phase  <= PH_HDR;
        bitCnt <= '0;
        outEn  <= 1'b0;
        outBit <= 1'b0;
      end else begin
        if (rise) begin
          shIn   <= nextSh;
          bitCnt <= bitCnt + BIT_W'(1);
          if (byteEnd) begin
            unique case (phase)
              PH_HDR: begin
                isRead    <= nextSh[BYTE_W-1];
                bytesLeft <= nextSh[ADDR_W +: CNT_W];
                addr      <= nextSh[ADDR_W-1:0];
                phase     <= PH_DATA;
              end
              PH_DATA: begin
                addr <= addr + ADDR_W'(1);
                if (bytesLeft == '0) phase <= PH_DONE;
                else bytesLeft <= bytesLeft - CNT_W'(1);
              end
              default: ;
            endcase
          end
        end
        if (fall) begin
          if (phase == PH_DATA && isRead) begin
            outEn <= 1'b1;
            if (bitCnt == '0) begin
              outBit <= rdData[BYTE_W-1];
              shOut  <= {rdData[BYTE_W-2:0], 1'b0};
            end else begin
              outBit <= shOut[BYTE_W-1];
              shOut  <= {shOut[BYTE_W-2:0], 1'b0};
            end
          end else begin
            outEn  <= 1'b0;
            outBit <= 1'b0;
          end
        end
      end
    end
  end

  assign sdoOut  = outEn && !threeWire && outBit;
  assign sdioOut = outEn && threeWire && outBit;
  assign sdioOe  = outEn && threeWire;
endmodule

// File: rtl/spiRegFile.sv
module spiRegFile
  import spiRegPkg::*;
#(
  parameter int STORE_PAGES = 4,
  parameter int STATUS_PAGE = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  regStrobe_t                             strb,
  input  logic [PAGE_DEPTH*BYTE_W-1:0]           statusIn,
  output logic [BYTE_W-1:0]                      rdData,
  output logic                                   threeWire,
  output logic [STORE_PAGES*PAGE_DEPTH*BYTE_W-1:0] regOut
);
  localparam int PIDX_W = (STORE_PAGES > 1) ? $clog2(STORE_PAGES) : 1;

  logic [BYTE_W-1:0] mem [STORE_PAGES][PAGE_DEPTH];
  logic [PAGE_W-1:0] page;
  logic [PIDX_W-1:0] pIdx;
  logic              isPtr, pageStored, isStatus, softRst;

  assign pIdx       = page[PIDX_W-1:0];
  assign isPtr      = (strb.addr == PAGE_PTR_ADDR);
  assign pageStored = (int'(page) < STORE_PAGES);
  assign isStatus   = (int'(page) == STATUS_PAGE);
  assign softRst    = (page == '0) && (strb.addr == MODE_ADDR) && strb.wrData[SOFTRST_BIT];

  always_comb begin
    if (isPtr)           rdData = BYTE_W'(page);
    else if (pageStored) rdData = mem[pIdx][strb.addr];
    else if (isStatus)   rdData = statusIn[strb.addr*BYTE_W +: BYTE_W];
    else                 rdData = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      page <= '0;
      for (int p = 0; p < STORE_PAGES; p++)
        for (int a = 0; a < PAGE_DEPTH; a++) mem[p][a] <= '0;
    end else if (strb.wrEn) begin
      if (isPtr) begin
        page <= strb.wrData[PAGE_W-1:0];
      end else if (softRst) begin
        page <= '0;
        for (int p = 0; p < STORE_PAGES; p++)
          for (int a = 0; a < PAGE_DEPTH; a++) mem[p][a] <= '0;
      end else if (pageStored) begin
        mem[pIdx][strb.addr] <= strb.wrData;
      end
    end
  end

  assign threeWire = mem[0][MODE_ADDR][WIRE3_BIT];

  for (genvar p = 0; p < STORE_PAGES; p++) begin : g_page
    for (genvar a = 0; a < PAGE_DEPTH; a++) begin : g_byte
      if (a == PAGE_DEPTH - 1) begin : g_ptr
        assign regOut[(p*PAGE_DEPTH+a)*BYTE_W +: BYTE_W] = BYTE_W'(page);
      end else begin : g_mem
        assign regOut[(p*PAGE_DEPTH+a)*BYTE_W +: BYTE_W] = mem[p][a];
      end
    end
  end
endmodule

// File: rtl/spiPagedRegs.sv
module spiPagedRegs
  import spiRegPkg::*;
#(
  parameter int STORE_PAGES = 4,
  parameter int STATUS_PAGE = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     csN,
  input  logic                                     sclk,
  input  logic                                     sdioIn,
  output logic                                     sdioOut,
  output logic                                     sdioOe,
  output logic                                     sdoOut,
  input  logic [PAGE_DEPTH*BYTE_W-1:0]             statusIn,
  output logic [STORE_PAGES*PAGE_DEPTH*BYTE_W-1:0] regOut
);
  regStrobe_t        strb;
  logic [BYTE_W-1:0] rdData;
  logic              threeWire;

  spiRegCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdioIn),
    .rdData(rdData), .threeWire(threeWire), .strb(strb),
    .sdoOut(sdoOut), .sdioOut(sdioOut), .sdioOe(sdioOe)
  );

  spiRegFile #(.STORE_PAGES(STORE_PAGES), .STATUS_PAGE(STATUS_PAGE)) file_i (
    .clk(clk), .rstN(rstN), .strb(strb), .statusIn(statusIn),
    .rdData(rdData), .threeWire(threeWire), .regOut(regOut)
  );
endmodule

// File: rtl/spiPagedRegsChk.sv
module spiPagedRegsChk #(
  parameter int REG_W = 1024
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             sdoOut,
  input logic             sdioOe,
  input logic [REG_W-1:0] regOut
);
  // R9
  onewire_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sdioOe && sdoOut));

  // R5
  page_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regOut[255:251] == 5'b0);

  // R11
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> (!sdioOe && !sdoOut));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |=> $stable(regOut));

  // R13
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (regOut == '0));
endmodule

bind spiPagedRegs spiPagedRegsChk #(.REG_W(STORE_PAGES*32*8)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .sdoOut(sdoOut), .sdioOe(sdioOe), .regOut(regOut)
);

// File: tb/spiPagedRegs_tb_top.sv
module spiPagedRegs_tb_top;
  localparam int STORE_PAGES = 4;
  localparam int HALF = 8;
  localparam int REG_W = STORE_PAGES * 32 * 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdioIn = 1'b0;
  logic sdioOut, sdioOe, sdoOut;
  logic [255:0] statusIn;
  logic [REG_W-1:0] regOut;

  spiPagedRegs dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut),
    .statusIn(statusIn), .regOut(regOut)
  );

  int checks = 0, fails = 0;
  logic [7:0] expQ[$], gotQ[$];
  string tagQ[$];
  logic [7:0] txBuf [0:4];
  bit oeSeen, sdoSeen;

  function automatic logic [7:0] statByte(int k);
    return 8'(8'hC0 ^ (k * 7));
  endfunction

  initial for (int k = 0; k < 32; k++) statusIn[k*8 +: 8] = statByte(k);

  function automatic logic [7:0] regByte(int p, int a);
    return regOut[(p*32+a)*8 +: 8];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (gotQ.size() != 0 && expQ.size() != 0) begin
      logic [7:0] g, e;
      string t;
      g = gotQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, 64'(g), 64'(e));
    end
  end

  task automatic expectRd(logic [7:0] v, string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  task automatic sclkBit(input logic dout, output logic din);
    @(negedge clk) sdioIn = dout;
    repeat (HALF) @(negedge clk);
    din = sdioOe ? sdioOut : sdoOut;
    if (sdioOe) oeSeen = 1'b1;
    if (sdoOut) sdoSeen = 1'b1;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  // header then nBits data bits; captured read bytes go to gotQ
  task automatic xfer(bit rd, int cnt, logic [4:0] addr, int nBits);
    logic [7:0] hdr, acc;
    logic b;
    hdr = {rd, 2'(cnt), addr};
    acc = '0;
    oeSeen = 1'b0;
    sdoSeen = 1'b0;
    @(negedge clk) csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 7; i >= 0; i--) sclkBit(hdr[i], b);
    for (int i = 0; i < nBits; i++) begin
      sclkBit(rd ? 1'b0 : txBuf[i/8][7 - (i%8)], b);
      acc = {acc[6:0], b};
      if (rd && (i % 8) == 7) gotQ.push_back(acc);
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic wr1(logic [4:0] addr, logic [7:0] v);
    txBuf[0] = v;
    xfer(1'b0, 0, addr, 8);
  endtask

  task automatic rd1(logic [4:0] addr, logic [7:0] exp, string tag);
    expectRd(exp, tag);
    xfer(1'b1, 0, addr, 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 regOut clear", 64'(regOut == '0), 64'd1);
    check("R1 sdoOut low", 64'(sdoOut), 64'd0);
    check("R1 sdioOe low", 64'(sdioOe), 64'd0);

    // R2 / R3 four-byte write from 03h on page 0
    txBuf[0] = 8'h11; txBuf[1] = 8'h22; txBuf[2] = 8'h33; txBuf[3] = 8'h44;
    xfer(1'b0, 3, 5'h03, 32);
    check("R2 page0 03h", 64'(regByte(0, 3)), 64'h11);
    check("R3 page0 04h", 64'(regByte(0, 4)), 64'h22);
    check("R3 page0 05h", 64'(regByte(0, 5)), 64'h33);
    check("R3 page0 06h", 64'(regByte(0, 6)), 64'h44);

    // R4 / R3 read back
    expectRd(8'h11, "R4 read 03h"); expectRd(8'h22, "R3 read 04h");
    expectRd(8'h33, "R3 read 05h"); expectRd(8'h44, "R3 read 06h");
    xfer(1'b1, 3, 5'h03, 32);
    check("R9 4-wire keeps sdioOe low", 64'(oeSeen), 64'd0);
    expectRd(8'h33, "R4 two-byte read 05h"); expectRd(8'h44, "R4 two-byte read 06h");
    xfer(1'b1, 1, 5'h05, 16);

    // R5 / R6 page pointer and page isolation
    wr1(5'h1F, 8'hF9);
    rd1(5'h1F, 8'h01, "R5 pointer reads low bits only");
    check("R5 regOut pointer slot", 64'(regByte(0, 31)), 64'h01);
    wr1(5'h07, 8'hA5);
    check("R6 page1 07h written", 64'(regByte(1, 7)), 64'hA5);
    check("R6 page0 07h untouched", 64'(regByte(0, 7)), 64'h00);
    rd1(5'h03, 8'h00, "R6 page1 03h independent");

    // R7 status page, reached from page 1
    wr1(5'h1F, 8'h04);
    rd1(5'h02, statByte(2), "R7 status read");
    wr1(5'h02, 8'hFF);
    rd1(5'h02, statByte(2), "R7 status write ignored");
    check("R7 stored pages untouched", 64'(regByte(0, 2) | regByte(1, 2)), 64'h00);

    // R8 unpopulated page
    wr1(5'h1F, 8'h06);
    rd1(5'h05, 8'h00, "R8 empty page reads zero");
    wr1(5'h05, 8'h77);
    rd1(5'h05, 8'h00, "R8 empty page write ignored");

    // R12 extra bytes ignored
    wr1(5'h1F, 8'h00);
    txBuf[0] = 8'h5A; txBuf[1] = 8'hC3;
    xfer(1'b0, 0, 5'h08, 16);
    check("R12 first byte stored", 64'(regByte(0, 8)), 64'h5A);
    check("R12 extra byte dropped", 64'(regByte(0, 9)), 64'h00);

    // R11 abort mid-byte
    txBuf[0] = 8'hFF;
    xfer(1'b0, 0, 5'h0A, 4);
    check("R11 partial byte discarded", 64'(regByte(0, 10)), 64'h00);
    wr1(5'h0A, 8'h3C);
    check("R11 next frame clean", 64'(regByte(0, 10)), 64'h3C);

    // R9 three-wire mode
    wr1(5'h00, 8'h80);
    check("R9 mode bit stored", 64'(regByte(0, 0)), 64'h80);
    rd1(5'h03, 8'h11, "R9 3-wire read data");
    check("R9 sdioOe raised", 64'(oeSeen), 64'd1);
    check("R9 sdoOut quiet", 64'(sdoSeen), 64'd0);

    // R10 soft reset
    wr1(5'h00, 8'h40);
    check("R10 all registers cleared", 64'(regOut == '0), 64'd1);
    rd1(5'h00, 8'h00, "R10 soft bit reads 0");
    check("R10 back to 4-wire", 64'(oeSeen), 64'd0);
    rd1(5'h1F, 8'h00, "R10 pointer cleared");

    // R13 hardware reset
    wr1(5'h03, 8'h99);
    check("R13 pre-reset write", 64'(regByte(0, 3)), 64'h99);
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 regOut cleared", 64'(regOut == '0), 64'd1);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check("R13 scoreboard drained", 64'(expQ.size() + gotQ.size()), 64'd0);
    summary();
  end
endmodule